// File: doc/BRIEF.md
# Transmit Byte FIFO with Byte and Word Push Ports

This block buffers outgoing data between a processor and a serial engine. The processor fills it through two push strobes. The byte port adds one byte per write. The word port adds a 32-bit word per write, and the word is split into four bytes that enter the queue least significant byte first. The serial engine drains the queue one byte at a time over a valid/ready handshake.

Free space is reported in bytes, not in entries, so software can decide whether to write whole words or single bytes. Three sticky interrupt flags are kept: the queue held no data, the queue was full, and a push was refused. Software clears the flags by writing 1 to them. A per-flag enable decides which flags drive the interrupt line. A word push that does not fit is refused as a whole, and the queue contents stay as they were.

Top module: `tfifo_bw_top`

## Requirements
- R1: A byte push is accepted when at least one byte is free and is refused otherwise. A refused byte never reaches the output.
- R2: An accepted word push stores four bytes, and they leave in the order bits 7:0, 15:8, 23:16, 31:24.
- R3: When both strobes are high in the same cycle, the word's bytes are queued ahead of the single byte. Each push is admitted against the space that is left after the pushes ahead of it, so a refused word does not stop a byte that fits.
- R4: A word push that arrives with fewer than four bytes free is refused in full. No byte of it is stored, and the free count and the queued data stay unchanged.
- R5: `tx_valid_o` is high exactly when the queue holds data. `tx_data_o` presents bytes in arrival order, and one byte leaves on each cycle in which `tx_valid_o` and `tx_ready_i` are both high.
- R6: `vacancy_o` bits 31:16 hold DEPTH minus the stored byte count, and bits 15:0 read zero. The value reflects every push and pop from the cycle after the clock edge that performs it.
- R7: Status bit 9 (empty) is set at every clock edge at which the queue holds no bytes. Status bit 10 (full) is set at every clock edge at which it holds DEPTH bytes.
- R8: Status bit 11 (overrun) is set at the clock edge at which any push is refused.
- R9: Each set `irq_ack_i` bit clears one status bit at the next edge: bit 0 clears bit 9, bit 1 clears bit 10, bit 2 clears bit 11. If the set condition is present in the same cycle, the set wins. All other status bits read zero.
- R10: `irq_o` is high exactly when some status bit among 11:9 is set and its enable in `irq_en_i` (same bit mapping as the acknowledge) is high.
- R11: While reset is asserted, the output is not valid, the free count equals DEPTH and all status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_push_i | input | 1 | Push strobe of the byte port |
| byte_data_i | input | 8 | Byte to push |
| word_push_i | input | 1 | Push strobe of the word port |
| word_data_i | input | 32 | Word to push, least significant byte first |
| irq_ack_i | input | 3 | Write-1-to-clear for status bits 9, 10, 11 |
| irq_en_i | input | 3 | Interrupt enables for status bits 9, 10, 11 |
| tx_valid_o | output | 1 | A byte is available toward the serial engine |
| tx_data_o | output | 8 | Byte at the head of the queue |
| tx_ready_i | input | 1 | The serial engine takes the head byte |
| vacancy_o | output | 32 | Free bytes in bits 31:16 |
| irq_status_o | output | 32 | Sticky flags in bits 11:9 |
| irq_o | output | 1 | Interrupt, level high |

## Verification
The main function is exercised with four kinds of push pattern:
- Separate byte pushes show that single bytes keep their arrival order.
- Word pushes of distinct bytes separate a correct least-significant-first unpack from a reversed or rotated one.
- Simultaneous word and byte strobes separate the intended lane order from a byte placed first or dropped.
- Pushes against a full or nearly full queue show whether a refused word is withheld completely or partly written.

Each pattern is drained and compared byte by byte. The free count is also checked, so a miscounted push shows up even when the data order happens to match.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
    // Positions of the sticky flags inside the interrupt status word
    localparam int FLAG_EMPTY_POS = 9;
    localparam int FLAG_FULL_POS  = 10;
    localparam int FLAG_OVR_POS   = 11;
    localparam int NUM_FLAGS      = 3;
    // Byte lanes written in one cycle: four from a word, one from the byte port
    localparam int NUM_LANES      = 5;

    typedef logic [7:0] byte_t;
endpackage

// File: rtl/tfifo_admit.sv
module tfifo_admit
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] free_i,
    input  logic          byte_push_i,
    input  byte_t         byte_data_i,
    input  logic          word_push_i,
    input  logic [31:0]   word_data_i,
    output logic [2:0]    lane_cnt_o,
    output byte_t         lanes_o [NUM_LANES],
    output logic          reject_o
);
    logic          word_ok;
    logic          byte_ok;
    logic [CW-1:0] room_after_word;

    always_comb begin
        word_ok         = word_push_i && (free_i >= CW'(4));
        room_after_word = word_ok ? (free_i - CW'(4)) : free_i;
        byte_ok         = byte_push_i && (room_after_word != '0);

        for (int k = 0; k < NUM_LANES; k++) lanes_o[k] = '0;
        if (word_ok) begin
            for (int k = 0; k < 4; k++) lanes_o[k] = word_data_i[8*k +: 8];
        end
        if (byte_ok) begin
            if (word_ok) lanes_o[4] = byte_data_i;
            else         lanes_o[0] = byte_data_i;
        end

        lane_cnt_o = (word_ok ? 3'd4 : 3'd0) + (byte_ok ? 3'd1 : 3'd0);
        reject_o   = (word_push_i && !word_ok) || (byte_push_i && !byte_ok);
    end
endmodule

// File: rtl/tfifo_store.sv
module tfifo_store
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [2:0]    lane_cnt_i,
    input  byte_t         lanes_i [NUM_LANES],
    input  logic          pop_i,
    output logic [CW-1:0] count_o,
    output byte_t         head_o
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         rd;
        logic [AW-1:0]         wr;
        logic [CW-1:0]         cnt;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_LANES; k++) begin
            if (3'(k) < lane_cnt_i) st_d.mem[st_q.wr + AW'(k)] = lanes_i[k];
        end
        st_d.wr  = st_q.wr + AW'(lane_cnt_i);
        st_d.rd  = pop_i ? st_q.rd + AW'(1) : st_q.rd;
        st_d.cnt = st_q.cnt + CW'(lane_cnt_i) - (pop_i ? CW'(1) : CW'(0));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign head_o  = st_q.mem[st_q.rd];
endmodule

// File: rtl/tfifo_irq.sv
module tfifo_irq
    import tfifo_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 empty_i,
    input  logic                 full_i,
    input  logic                 reject_i,
    input  logic [NUM_FLAGS-1:0] ack_i,
    input  logic [NUM_FLAGS-1:0] en_i,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
    } irq_t;

    irq_t ir_d, ir_q;

    always_comb begin
        ir_d       = ir_q;
        // Clearing first and setting after, so a present cause wins
        ir_d.flags = (ir_q.flags & ~ack_i) | {reject_i, full_i, empty_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ir_q <= '0;
        else         ir_q <= ir_d;
    end

    assign flags_o = ir_q.flags;
    assign irq_o   = |(ir_q.flags & en_i);
endmodule

// File: rtl/tfifo_bw_top.sv
module tfifo_bw_top
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        byte_push_i,
    input  logic [7:0]  byte_data_i,
    input  logic        word_push_i,
    input  logic [31:0] word_data_i,
    input  logic [2:0]  irq_ack_i,
    input  logic [2:0]  irq_en_i,
    output logic        tx_valid_o,
    output logic [7:0]  tx_data_o,
    input  logic        tx_ready_i,
    output logic [31:0] vacancy_o,
    output logic [31:0] irq_status_o,
    output logic        irq_o
);
    logic [CW-1:0]        count;
    logic [CW-1:0]        free;
    logic [2:0]           lane_cnt;
    byte_t                lanes [NUM_LANES];
    logic                 reject;
    logic                 pop;
    logic [NUM_FLAGS-1:0] flags;

    assign free       = CW'(DEPTH) - count;
    assign tx_valid_o = (count != '0);
    assign pop        = tx_valid_o && tx_ready_i;

    tfifo_admit #(.DEPTH(DEPTH)) u_admit (
        .free_i      (free),
        .byte_push_i (byte_push_i),
        .byte_data_i (byte_data_i),
        .word_push_i (word_push_i),
        .word_data_i (word_data_i),
        .lane_cnt_o  (lane_cnt),
        .lanes_o     (lanes),
        .reject_o    (reject)
    );

    tfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .lane_cnt_i (lane_cnt),
        .lanes_i    (lanes),
        .pop_i      (pop),
        .count_o    (count),
        .head_o     (tx_data_o)
    );

    tfifo_irq u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .empty_i  (count == '0),
        .full_i   (count == CW'(DEPTH)),
        .reject_i (reject),
        .ack_i    (irq_ack_i),
        .en_i     (irq_en_i),
        .flags_o  (flags),
        .irq_o    (irq_o)
    );

    assign vacancy_o = {16'(free), 16'h0000};

    always_comb begin
        irq_status_o = '0;
        irq_status_o[FLAG_OVR_POS:FLAG_EMPTY_POS] = flags;
    end
endmodule

// File: rtl/tfifo_bw_checker.sv
module tfifo_bw_checker #(
    parameter int DEPTH = 16
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        byte_push_i,
    input logic        word_push_i,
    input logic [2:0]  irq_ack_i,
    input logic [2:0]  irq_en_i,
    input logic        tx_valid_o,
    input logic        tx_ready_i,
    input logic [31:0] vacancy_o,
    input logic [31:0] irq_status_o,
    input logic        irq_o
);
    logic [15:0] free_w;
    assign free_w = vacancy_o[31:16];

    // R5
    a_r5_valid_iff_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_valid_o == (free_w != 16'(DEPTH)));

    // R6
    a_r6_free_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (free_w <= 16'(DEPTH)) && (vacancy_o[15:0] == 16'h0));

    // R2
    a_r2_word_takes_four: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_push_i && !byte_push_i && !(tx_valid_o && tx_ready_i) && free_w >= 16'd4)
        |=> free_w == $past(free_w) - 16'd4);

    // R4
    a_r4_short_word_kept_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_push_i && !byte_push_i && !(tx_valid_o && tx_ready_i) && free_w < 16'd4)
        |=> $stable(free_w));

    // R8
    a_r8_refusal_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((word_push_i && free_w < 16'd4) || (byte_push_i && free_w == 16'd0))
        |=> irq_status_o[11]);

    // R7
    a_r7_full_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (free_w == 16'd0) |=> irq_status_o[10]);

    // R9
    a_r9_ack_clears_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_ack_i[2] && !word_push_i && !byte_push_i) |=> !irq_status_o[11]);

    // R10
    a_r10_irq_needs_enabled_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((irq_status_o[11:9] & irq_en_i) != 3'b000));
endmodule

bind tfifo_bw_top tfifo_bw_checker #(.DEPTH(DEPTH)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_push_i  (byte_push_i),
    .word_push_i  (word_push_i),
    .irq_ack_i    (irq_ack_i),
    .irq_en_i     (irq_en_i),
    .tx_valid_o   (tx_valid_o),
    .tx_ready_i   (tx_ready_i),
    .vacancy_o    (vacancy_o),
    .irq_status_o (irq_status_o),
    .irq_o        (irq_o)
);

// File: tb/tfifo_bw_top_test.sv
module tfifo_bw_top_test;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_push = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        word_push = 1'b0;
    logic [31:0] word_data = '0;
    logic [2:0]  ack = '0;
    logic [2:0]  en = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic [31:0] vacancy;
    logic [31:0] status;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] model[$];

    always #2.5 clk = ~clk;

    tfifo_bw_top #(.DEPTH(DEPTH)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .byte_push_i(byte_push), .byte_data_i(byte_data),
        .word_push_i(word_push), .word_data_i(word_data),
        .irq_ack_i(ack), .irq_en_i(en),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
        .vacancy_o(vacancy), .irq_status_o(status), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] vac(input int n);
        return {16'(DEPTH - n), 16'h0};
    endfunction

    // Called at a falling edge; returns at the next falling edge with the push applied
    task automatic push(input logic b, input logic [7:0] bd, input logic w,
                        input logic [31:0] wd, output logic rej);
        int room;
        logic wok, bok;
        room = DEPTH - model.size();
        wok = w && room >= 4;
        if (wok) begin
            for (int k = 0; k < 4; k++) model.push_back(wd[8*k +: 8]);
            room -= 4;
        end
        bok = b && room >= 1;
        if (bok) model.push_back(bd);
        rej = (w && !wok) || (b && !bok);
        byte_push = b; byte_data = bd; word_push = w; word_data = wd;
        @(negedge clk);
        byte_push = 1'b0; word_push = 1'b0;
    endtask

    task automatic pulse_ack(input logic [2:0] a);
        ack = a;
        @(negedge clk);
        ack = '0;
    endtask

    task automatic drain(input string req);
        tx_ready = 1'b1;
        while (model.size() > 0) begin
            check({req, " valid"}, {31'b0, tx_valid}, 32'd1);
            check({req, " data"}, {24'b0, tx_data}, {24'b0, model.pop_front()});
            @(negedge clk);
        end
        tx_ready = 1'b0;
        check({req, " drained"}, {31'b0, tx_valid}, 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R11 valid in reset", {31'b0, tx_valid}, 32'd0);
        check("R11 vacancy in reset", vacancy, vac(0));
        check("R11 status in reset", status, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 empty flag bit 9", status, 32'h200);
        check("R10 irq masked", {31'b0, irq}, 32'd0);
        en = 3'b001;
        #1;
        check("R10 irq enabled", {31'b0, irq}, 32'd1);
        en = 3'b000;
    endtask

    task automatic t_bytes;
        logic r;
        push(1, 8'h5A, 0, 0, r);
        push(1, 8'h01, 0, 0, r);
        push(1, 8'hF0, 0, 0, r);
        check("R6 vacancy after 3 bytes", vacancy, vac(3));
        check("R1 byte accepted", {31'b0, r}, 32'd0);
        drain("R1 R5 byte order");
        check("R6 vacancy after drain", vacancy, vac(0));
    endtask

    task automatic t_word;
        logic r;
        push(0, 0, 1, 32'hA1B2C3D4, r);
        check("R2 vacancy after word", vacancy, vac(4));
        drain("R2 lsb first");
    endtask

    task automatic t_both;
        logic r;
        push(1, 8'h55, 1, 32'h44332211, r);
        check("R3 vacancy after both", vacancy, vac(5));
        drain("R3 word then byte");
    endtask

    task automatic t_full;
        logic r;
        pulse_ack(3'b111);
        for (int i = 0; i < 4; i++) push(0, 0, 1, 32'h10203040 + 32'(i), r);
        check("R6 vacancy full", vacancy, vac(DEPTH));
        @(negedge clk);
        check("R7 full flag bit 10", {31'b0, status[10]}, 32'd1);
        check("R8 no overrun yet", {31'b0, status[11]}, 32'd0);
        push(0, 0, 1, 32'hDEADBEEF, r);
        check("R8 overrun after word refused", {31'b0, status[11]}, 32'd1);
        check("R4 vacancy unchanged", vacancy, vac(DEPTH));
        push(1, 8'hEE, 0, 0, r);
        check("R1 byte refused when full", {31'b0, r}, 32'd1);
        check("R1 vacancy unchanged", vacancy, vac(DEPTH));
        drain("R4 contents intact");
    endtask

    task automatic t_partial;
        logic r;
        pulse_ack(3'b111);
        for (int i = 0; i < 3; i++) push(0, 0, 1, 32'hC0C1C2C3 ^ 32'(i), r);
        push(1, 8'h77, 0, 0, r);
        check("R6 vacancy 3 free", vacancy, vac(13));
        @(negedge clk);
        check("R8 clear before refusal", {31'b0, status[11]}, 32'd0);
        push(0, 0, 1, 32'h99887766, r);
        check("R4 short word refused", {31'b0, r}, 32'd1);
        check("R4 no partial write", vacancy, vac(13));
        check("R8 overrun on short word", {31'b0, status[11]}, 32'd1);
        push(1, 8'h3C, 1, 32'h12345678, r);
        check("R3 byte admitted past refused word", vacancy, vac(14));
        drain("R3 R4 partial contents");
    endtask

    task automatic t_clear;
        logic r;
        pulse_ack(3'b001);
        check("R9 set wins over ack while empty", {31'b0, status[9]}, 32'd1);
        push(1, 8'hAB, 0, 0, r);
        pulse_ack(3'b111);
        check("R9 all flags cleared", status, 32'h0);
        en = 3'b111;
        #1;
        check("R10 irq low with no flags", {31'b0, irq}, 32'd0);
        en = 3'b000;
        drain("R9 byte kept");
    endtask

    task automatic t_concurrent;
        logic r;
        push(1, 8'h61, 0, 0, r);
        tx_ready = 1'b1;
        void'(model.pop_front());
        push(0, 0, 1, 32'h65646362, r);
        tx_ready = 1'b0;
        check("R5 R6 pop and push together", vacancy, vac(4));
        drain("R5 order after concurrent");
    endtask

    initial begin
        t_reset();
        t_bytes();
        t_word();
        t_both();
        t_full();
        t_partial();
        t_clear();
        t_concurrent();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule